// File: doc/BRIEF.md
# Quadrature Chroma Demodulator

This block turns a stream of 8-bit signed chroma samples into two colour-difference components, U and V. A phase accumulator advances by a programmable increment on every accepted sample. The top bits of the accumulator index a quarter-wave symmetric sine shape, which gives an in-phase reference and a reference shifted by a quarter turn. Each sample is multiplied by both references in two separate multipliers. Because the increment is an input, the same block can follow the subcarrier of any colour standard.

Each product stream passes through a low-pass filter built from a cascade of two-tap moving-average sections. A two-bit code chosen with each sample sets how many sections, from one to four, feed the output. All sections keep their history whatever the code is, so a code change needs no flush. The result is rounded, scaled back to 8 bits and saturated. U and V leave together with one valid strobe after a fixed delay.

Top module: `chroma_qdemod`

## Requirements
- R1: While `rst` is high and after it falls, until the first result, `out_valid` is 0 and `u_out`, `v_out` are 0; the phase accumulator restarts at 0.
- R2: The 32-bit accumulator adds `phase_inc` once for every cycle with `in_valid` high and holds otherwise; a sample uses the accumulator value from before its own addition, and its phase index is the top 8 bits.
- R3: For phase index p, the reference is sign*((q*(128-q)*127)>>12), with h = p mod 128, q = h for h<64 and q = 128-h for h>=64, and sign negative for p>=128; the in-phase reference uses p and the quadrature reference uses (p+64) mod 256, so both stay within -127..127.
- R4: The U product is the chroma sample times the in-phase reference, and the V product is the same sample times the quadrature reference.
- R5: Filter code f (0..3) is taken with its sample and selects s = f+1 sections, giving the sum over j=0..s of C(s,j) times the product of the j-th previous accepted sample (zero before the first sample after reset).
- R6: Each output equals floor((sum + 2^(s+6)) / 2^(s+7)), saturated to -128..127.
- R7: A sample accepted at a clock edge produces `out_valid` high for one cycle two edges later, with U and V updated together; between results both outputs hold their values.
- R8: All filter sections advance on every accepted sample, so a code that differs from the previous sample's code applies at once to the result of its own sample.
- R9: In cycles with `in_valid` low, `chroma_in`, `filt_sel` and `phase_inc` have no effect on the accumulator, the filter history or any later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| chroma_in | input | 8 | Signed chroma sample |
| phase_inc | input | 32 | Accumulator increment per sample |
| filt_sel | input | 2 | Filter code, taken with the sample |
| out_valid | output | 1 | Result strobe |
| u_out | output | 8 | Signed U component |
| v_out | output | 8 | Signed V component |

## Verification
The hardest state to reach from the ports is a filter history that holds four earlier products of different signs, then read through a filter code that changes from sample to sample, after idle cycles in which every other input moved. The stimulus mixes back-to-back samples with gaps of random length in which chroma, code and increment are all randomised. It also adds directed runs with a zero increment and with quarter-turn and near-full-turn increments, so that the phase index lands on the quadrant edges and the extreme sample -128 passes through the deepest filter.

// File: rtl/chroma_qdemod_pkg.sv
package chroma_qdemod_pkg;
  localparam int SMP_W  = 8;               // chroma sample width
  localparam int PH_W   = 8;               // phase index width
  localparam int REF_W  = 8;               // reference width
  localparam int NSTAGE = 4;               // moving-average sections
  localparam int SEL_W  = $clog2(NSTAGE);
  localparam int OUT_W  = 8;
  localparam int PROD_W = SMP_W + REF_W;
  localparam int SUM_W  = PROD_W + NSTAGE;
  localparam int QTR    = 1 << (PH_W - 2);
  localparam int AMP    = (1 << (REF_W - 1)) - 1;
  localparam int OMAX   = (1 << (OUT_W - 1)) - 1;
  localparam int OMIN   = -(1 << (OUT_W - 1));

  // quarter-wave parabolic sine shape, mirrored and negated per quadrant
  function automatic logic signed [REF_W-1:0] ref_lookup(input logic [PH_W-1:0] ph);
    logic [PH_W-2:0] idx;
    int m;
    if (ph[PH_W-2]) idx = (PH_W-1)'(QTR - int'(ph[PH_W-3:0]));
    else            idx = {1'b0, ph[PH_W-3:0]};
    m = (int'(idx) * (2 * QTR - int'(idx)) * AMP) >>> (2 * (PH_W - 2));
    if (ph[PH_W-1]) m = -m;
    return REF_W'(m);
  endfunction

  // round half up, arithmetic shift, clamp to output range
  function automatic logic signed [OUT_W-1:0] round_sat(input logic signed [SUM_W-1:0] v,
                                                        input int sh);
    logic signed [SUM_W:0] t;
    int r;
    t = {v[SUM_W-1], v};
    t = t + ((SUM_W+1)'(1) << (sh - 1));
    t = t >>> sh;
    r = int'(t);
    if (r > OMAX) r = OMAX;
    if (r < OMIN) r = OMIN;
    return OUT_W'(r);
  endfunction
endpackage

// File: rtl/chroma_dto.sv
module chroma_dto
  import chroma_qdemod_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic [ACC_W-1:0]        inc,
  output logic [ACC_W-1:0]        phase_acc,
  output logic signed [REF_W-1:0] ref0,
  output logic signed [REF_W-1:0] ref90
);
  logic [PH_W-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst)      phase_acc <= '0;
    else if (adv) phase_acc <= phase_acc + inc;
  end

  assign ph    = phase_acc[ACC_W-1 -: PH_W];
  assign ref0  = ref_lookup(ph);
  assign ref90 = ref_lookup(ph + PH_W'(QTR));
endmodule

// File: rtl/chroma_lpf.sv
module chroma_lpf
  import chroma_qdemod_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [PROD_W-1:0] din,
  input  logic [SEL_W-1:0]         sel,
  output logic signed [OUT_W-1:0]  q
);
  logic signed [SUM_W-1:0] tap  [0:NSTAGE];
  logic signed [SUM_W-1:0] hist [0:NSTAGE-1];
  logic [SEL_W:0]          nst;

  assign tap[0] = SUM_W'(din);

  for (genvar g = 0; g < NSTAGE; g++) begin : g_sec
    assign tap[g+1] = tap[g] + hist[g];
    always_ff @(posedge clk) begin
      if (rst)     hist[g] <= '0;
      else if (en) hist[g] <= tap[g];
    end
  end

  assign nst = {1'b0, sel} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= round_sat(tap[nst], int'(nst) + REF_W - 1);
  end
endmodule

// File: rtl/chroma_qdemod.sv
module chroma_qdemod
  import chroma_qdemod_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [SMP_W-1:0] chroma_in,
  input  logic [ACC_W-1:0]        phase_inc,
  input  logic [SEL_W-1:0]        filt_sel,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] u_out,
  output logic signed [OUT_W-1:0] v_out
);
  localparam int NCH = 2;

  logic [ACC_W-1:0]         phase_acc;
  logic signed [REF_W-1:0]  ref0, ref90;
  logic signed [REF_W-1:0]  refs [NCH];
  logic signed [PROD_W-1:0] prod [NCH];
  logic signed [OUT_W-1:0]  res  [NCH];
  logic                     prod_valid;
  logic [SEL_W-1:0]         sel_r;

  chroma_dto #(.ACC_W(ACC_W)) u_dto (
    .clk(clk), .rst(rst), .adv(in_valid), .inc(phase_inc),
    .phase_acc(phase_acc), .ref0(ref0), .ref90(ref90)
  );

  assign refs[0] = ref0;
  assign refs[1] = ref90;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_valid <= 1'b0;
      sel_r      <= '0;
      out_valid  <= 1'b0;
    end else begin
      prod_valid <= in_valid;
      out_valid  <= prod_valid;
      if (in_valid) sel_r <= filt_sel;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)           prod[c] <= '0;
      else if (in_valid) prod[c] <= PROD_W'(chroma_in) * PROD_W'(refs[c]);
    end

    chroma_lpf u_lpf (
      .clk(clk), .rst(rst), .en(prod_valid),
      .din(prod[c]), .sel(sel_r), .q(res[c])
    );
  end

  assign u_out = res[0];
  assign v_out = res[1];
endmodule

// File: rtl/chroma_qdemod_chk.sv
module chroma_qdemod_chk
  import chroma_qdemod_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [ACC_W-1:0]        phase_inc,
  input logic [ACC_W-1:0]        phase_acc,
  input logic signed [REF_W-1:0] ref0,
  input logic signed [REF_W-1:0] ref90,
  input logic                    prod_valid,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] u_out,
  input logic signed [OUT_W-1:0] v_out
);
  // R2: accumulator step and hold
  p_acc_step_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> phase_acc == $past(phase_acc) + $past(phase_inc));
  p_acc_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(phase_acc));

  // R3: quadrant edges of the two references
  p_ref_zero_r3: assert property (@(posedge clk) disable iff (rst)
    phase_acc[ACC_W-1 -: PH_W] == '0 |-> (ref0 == 8'sd0 && ref90 == 8'sd127));
  p_ref_half_r3: assert property (@(posedge clk) disable iff (rst)
    phase_acc[ACC_W-1 -: PH_W] == PH_W'(2 * QTR) |-> (ref0 == 8'sd0 && ref90 == -8'sd127));
  p_ref_range_r3: assert property (@(posedge clk) disable iff (rst)
    ref0 != -8'sd128 && ref90 != -8'sd128);

  // R7: fixed two-edge latency and held outputs
  p_lat_a_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> prod_valid);
  p_lat_b_r7: assert property (@(posedge clk) disable iff (rst)
    prod_valid |=> out_valid);
  p_lat_c_r7: assert property (@(posedge clk) disable iff (rst)
    !prod_valid |=> !out_valid);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !prod_valid |=> ($stable(u_out) && $stable(v_out)));
endmodule

bind chroma_qdemod chroma_qdemod_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .phase_inc(phase_inc),
  .phase_acc(phase_acc), .ref0(ref0), .ref90(ref90), .prod_valid(prod_valid),
  .out_valid(out_valid), .u_out(u_out), .v_out(v_out)
);

// File: tb/sim_chroma_qdemod.sv
module sim_chroma_qdemod;
  localparam int CLK_P = 10;
  localparam int WD_CYC = 100000;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic signed [7:0] chroma_in = '0;
  logic [31:0] phase_inc = '0;
  logic [1:0]  filt_sel = '0;
  logic out_valid;
  logic signed [7:0] u_out, v_out;

  int n_run = 0, n_fail = 0;
  longint unsigned acc_m = 0;
  int hu[5], hv[5];
  int qu[$], qv[$];
  int last_u = 0, last_v = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  chroma_qdemod u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .chroma_in(chroma_in),
    .phase_inc(phase_inc), .filt_sel(filt_sel), .out_valid(out_valid),
    .u_out(u_out), .v_out(v_out)
  );

  function automatic int bref(int p);
    int h, m;
    h = p % 128;
    m = h * (128 - h) * 127 / 4096;
    return (p >= 128) ? -m : m;
  endfunction

  function automatic int binom(int n, int k);
    int r = 1;
    for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
    return r;
  endfunction

  function automatic int bout(int h[5], int s);
    int sum = 0, t;
    for (int j = 0; j <= s; j++) sum += binom(s, j) * h[j];
    t = (sum + (1 << (s + 6))) >>> (s + 7);
    if (t > 127) t = 127;
    if (t < -128) t = -128;
    return t;
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R4 R5 R6 model, then drive one accepted sample followed by a noisy gap (R9)
  task automatic send(int x, int f, logic [31:0] inc, int gap);
    int p;
    p = int'(acc_m >> 24);
    for (int j = 4; j > 0; j--) begin hu[j] = hu[j-1]; hv[j] = hv[j-1]; end
    hu[0] = x * bref(p);
    hv[0] = x * bref((p + 64) % 256);
    qu.push_back(bout(hu, f + 1));
    qv.push_back(bout(hv, f + 1));
    acc_m = (acc_m + inc) & 64'hFFFF_FFFF;
    in_valid = 1'b1; chroma_in = 8'(x); filt_sel = 2'(f); phase_inc = inc;
    @(negedge clk);
    if (gap > 0) begin
      in_valid = 1'b0;
      for (int g = 0; g < gap; g++) begin
        chroma_in = 8'($urandom); filt_sel = 2'($urandom); phase_inc = $urandom;
        @(negedge clk);
      end
    end
  endtask

  // output monitor: R5 R6 values, R7 hold between results
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (qu.size() == 0) check("R7 spurious out_valid", 1, 0);
        else begin
          check("R5/R6 u_out", int'(u_out), qu.pop_front());
          check("R5/R6 v_out", int'(v_out), qv.pop_front());
        end
        last_u = int'(u_out); last_v = int'(v_out);
      end else begin
        check("R7 u_out hold", int'(u_out), last_u);
        check("R7 v_out hold", int'(v_out), last_v);
      end
    end
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", WD_CYC, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7095));
    for (int j = 0; j < 5; j++) begin hu[j] = 0; hv[j] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 u_out in reset", int'(u_out), 0);
    check("R1 v_out in reset", int'(v_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);

    // R7: latency of a single sample (R1: accumulator starts at phase 0, U = 0)
    send(100, 0, 32'h0, 0);
    in_valid = 1'b0;
    check("R7 out_valid one edge later", int'(out_valid), 0);
    @(negedge clk);
    check("R7 out_valid two edges later", int'(out_valid), 1);
    check("R1 u_out at phase zero", int'(u_out), 0);
    @(negedge clk);
    check("R7 out_valid pulse length", int'(out_valid), 0);

    // R5 R8: zero increment, constant input, filter code stepping each sample
    for (int k = 0; k < 8; k++) send(100, k % 4, 32'h0, 0);
    // R6 R3: extreme negative sample through deepest filter
    for (int k = 0; k < 6; k++) send(-128, 3, 32'h0, k % 2);
    // R2 R3: quarter-turn increment hits every quadrant edge
    for (int k = 0; k < 12; k++) send(127, k % 4, 32'h4000_0000, 0);
    for (int k = 0; k < 12; k++) send(-128, 3, 32'h4000_0000, 1);
    // R2: near-full-turn increment wraps the accumulator
    for (int k = 0; k < 10; k++) send(int'($urandom_range(255)) - 128, 2, 32'hFFFF_FFFF, 0);
    // R9: long gaps with all inputs noisy
    for (int k = 0; k < 8; k++) send(-77, 1, 32'h1234_5678, 6);

    // random mix
    for (int k = 0; k < 2000; k++)
      send(int'($urandom_range(255)) - 128, int'($urandom_range(3)), $urandom,
           ($urandom_range(3) == 0) ? int'($urandom_range(4)) : 0);

    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 every sample produced a result", qu.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule